// File: doc/BRIEF.md
# Address Space Identifier Selector and Privilege Checker

Every load or store carries an 8-bit address space identifier (ASI). This block decides which identifier applies to the current access. It also works out the byte order that identifier implies, and it flags a privileged-action exception when non-privileged code names a restricted identifier.

An ordinary access takes an implicit identifier. That identifier is primary or nucleus, in a big-endian or little-endian form, and a default byte-order control bit chooses between the two forms. An alternate access names its identifier explicitly, either from the instruction's immediate field or from the ASI register, as chosen by the immediate-select bit. Instruction fetches always use the big-endian implicit identifier.

All three results are registered, so they appear one clock after the inputs are sampled. Byte swapping of the data and address translation are handled downstream.

Top module: `asi_sel_check`

## Requirements
- R1: While rst_ni is low, asi_o is 0x00 and little_o and priv_exc_o are 0. The reset is asynchronous.
- R2: The outputs change only at a rising clock edge. They reflect the inputs sampled at the previous rising edge.
- R3: For a non-alternate data access (alt_i=0, ifetch_i=0) with nucleus_i=0, asi_o is 0x80. If dflt_le_i=1, asi_o is 0x88 instead.
- R4: For a non-alternate data access with nucleus_i=1, asi_o is 0x04. If dflt_le_i=1, asi_o is 0x0C instead.
- R5: An alternate data access (alt_i=1) with imm_sel_i=0 sets asi_o to imm_asi_i.
- R6: An alternate data access with imm_sel_i=1 sets asi_o to asi_reg_i.
- R7: priv_exc_o is 1 when all of the following hold: alt_i=1, ifetch_i=0, priv_i=0, and the selected identifier is in 0x00..0x7F (bit 7 clear).
- R8: priv_exc_o is 0 when the selected identifier is in 0x80..0xFF, when priv_i=1, or for any implicit identifier. This holds even for a non-privileged nucleus access.
- R9: little_o is 1 exactly when the selected identifier is 0x88 or 0x0C and the access is not a fetch. Every other value, such as 0x8C, gives big-endian (little_o=0).
- R10: When ifetch_i=1, alt_i, imm_sel_i and dflt_le_i are ignored. In that case asi_o is 0x80 (nucleus_i=0) or 0x04 (nucleus_i=1), and little_o and priv_exc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_i | input | 1 | Access is an alternate load/store |
| imm_sel_i | input | 1 | Immediate-select bit: 0 uses the immediate field, 1 uses the ASI register |
| imm_asi_i | input | 8 | Immediate ASI field of the instruction |
| asi_reg_i | input | 8 | Current ASI register value |
| nucleus_i | input | 1 | Nucleus context is active |
| dflt_le_i | input | 1 | Default byte order for implicit data accesses is little-endian |
| priv_i | input | 1 | Processor is in privileged mode |
| ifetch_i | input | 1 | Access is an instruction fetch |
| asi_o | output | 8 | Selected ASI |
| little_o | output | 1 | Access is little-endian |
| priv_exc_o | output | 1 | Privileged-action exception |

## Verification
The byte-order decode and the privilege check both act on the same selected identifier, so they can both fire in the same cycle. The bench provokes this with a non-privileged alternate access naming 0x0C, first from the immediate field and then from the register. It expects little_o and priv_exc_o to rise together one clock later. The same identifier issued in privileged mode must leave only little_o set, and issued as a fetch must clear both, which separates the two paths.

// File: rtl/asi_pkg.sv
package asi_pkg;
  localparam int unsigned ASI_W = 8;
  typedef logic [ASI_W-1:0] asi_t;

  localparam asi_t ASI_PRI    = 8'h80;
  localparam asi_t ASI_PRI_LE = 8'h88;
  localparam asi_t ASI_NUC    = 8'h04;
  localparam asi_t ASI_NUC_LE = 8'h0C;
  localparam asi_t ASI_RST    = 8'h00;

  typedef enum logic [1:0] {
    SRC_IMPL = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_REG  = 2'd2
  } asi_src_e;

  typedef struct packed {
    asi_t asi;
    logic little;
    logic priv_exc;
  } asi_res_t;
endpackage

// File: rtl/asi_source_mux.sv
module asi_source_mux
  import asi_pkg::*;
#(
  parameter asi_t PRI    = ASI_PRI,
  parameter asi_t PRI_LE = ASI_PRI_LE,
  parameter asi_t NUC    = ASI_NUC,
  parameter asi_t NUC_LE = ASI_NUC_LE
) (
  input  logic     alt_i,
  input  logic     imm_sel_i,
  input  asi_t     imm_asi_i,
  input  asi_t     asi_reg_i,
  input  logic     nucleus_i,
  input  logic     dflt_le_i,
  input  logic     ifetch_i,
  output asi_t     asi_o,
  output asi_src_e src_o
);
  logic impl_le;
  asi_t impl_asi;

  // fetches never pick up the little-endian default
  assign impl_le = dflt_le_i & ~ifetch_i;

  always_comb begin
    if (nucleus_i) impl_asi = impl_le ? NUC_LE : NUC;
    else           impl_asi = impl_le ? PRI_LE : PRI;
  end

  always_comb begin
    if (ifetch_i || !alt_i) src_o = SRC_IMPL;
    else if (imm_sel_i)     src_o = SRC_REG;
    else                    src_o = SRC_IMM;
  end

  always_comb begin
    unique case (src_o)
      SRC_IMM: asi_o = imm_asi_i;
      SRC_REG: asi_o = asi_reg_i;
      default: asi_o = impl_asi;
    endcase
  end
endmodule

// File: rtl/asi_attr_decode.sv
module asi_attr_decode
  import asi_pkg::*;
#(
  parameter asi_t PRI_LE = ASI_PRI_LE,
  parameter asi_t NUC_LE = ASI_NUC_LE
) (
  input  asi_t     asi_i,
  input  asi_src_e src_i,
  input  logic     priv_i,
  input  logic     ifetch_i,
  output asi_res_t res_o
);
  localparam int unsigned RESTR_BIT = ASI_W - 1;

  logic le_code;
  logic restricted;

  assign le_code    = (asi_i == PRI_LE) || (asi_i == NUC_LE);
  assign restricted = ~asi_i[RESTR_BIT];

  always_comb begin
    res_o.asi      = asi_i;
    res_o.little   = le_code & ~ifetch_i;
    res_o.priv_exc = (src_i != SRC_IMPL) & restricted & ~priv_i;
  end
endmodule

// File: rtl/asi_sel_check.sv
module asi_sel_check
  import asi_pkg::*;
#(
  parameter asi_t PRI    = ASI_PRI,
  parameter asi_t PRI_LE = ASI_PRI_LE,
  parameter asi_t NUC    = ASI_NUC,
  parameter asi_t NUC_LE = ASI_NUC_LE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alt_i,
  input  logic       imm_sel_i,
  input  logic [7:0] imm_asi_i,
  input  logic [7:0] asi_reg_i,
  input  logic       nucleus_i,
  input  logic       dflt_le_i,
  input  logic       priv_i,
  input  logic       ifetch_i,
  output logic [7:0] asi_o,
  output logic       little_o,
  output logic       priv_exc_o
);
  asi_t     sel_asi;
  asi_src_e sel_src;
  asi_res_t res_d, res_q;

  asi_source_mux #(
    .PRI(PRI), .PRI_LE(PRI_LE), .NUC(NUC), .NUC_LE(NUC_LE)
  ) u_mux (
    .alt_i     (alt_i),
    .imm_sel_i (imm_sel_i),
    .imm_asi_i (imm_asi_i),
    .asi_reg_i (asi_reg_i),
    .nucleus_i (nucleus_i),
    .dflt_le_i (dflt_le_i),
    .ifetch_i  (ifetch_i),
    .asi_o     (sel_asi),
    .src_o     (sel_src)
  );

  asi_attr_decode #(
    .PRI_LE(PRI_LE), .NUC_LE(NUC_LE)
  ) u_dec (
    .asi_i    (sel_asi),
    .src_i    (sel_src),
    .priv_i   (priv_i),
    .ifetch_i (ifetch_i),
    .res_o    (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '{asi: ASI_RST, little: 1'b0, priv_exc: 1'b0};
    end else begin
      res_q <= res_d;
    end
  end

  assign asi_o      = res_q.asi;
  assign little_o   = res_q.little;
  assign priv_exc_o = res_q.priv_exc;
endmodule

// File: rtl/asi_sel_check_chk.sv
module asi_sel_check_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       alt_i,
  input logic       imm_sel_i,
  input logic [7:0] imm_asi_i,
  input logic [7:0] asi_reg_i,
  input logic       priv_i,
  input logic       ifetch_i,
  input logic [7:0] asi_o,
  input logic       little_o,
  input logic       priv_exc_o
);
  assert_rst_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (asi_o == 8'h00) && !little_o && !priv_exc_o);

  assert_imm_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_i && !imm_sel_i && !ifetch_i) |=> asi_o == $past(imm_asi_i));

  assert_reg_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_i && imm_sel_i && !ifetch_i) |=> asi_o == $past(asi_reg_i));

  assert_exc_restricted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_exc_o |-> !asi_o[7]);

  assert_no_exc_priv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i || !alt_i) |=> !priv_exc_o);

  assert_le_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    little_o |-> (asi_o == 8'h88 || asi_o == 8'h0C));

  assert_fetch_big_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifetch_i |=> !little_o && !priv_exc_o && !asi_o[3]);
endmodule

bind asi_sel_check asi_sel_check_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alt_i      (alt_i),
  .imm_sel_i  (imm_sel_i),
  .imm_asi_i  (imm_asi_i),
  .asi_reg_i  (asi_reg_i),
  .priv_i     (priv_i),
  .ifetch_i   (ifetch_i),
  .asi_o      (asi_o),
  .little_o   (little_o),
  .priv_exc_o (priv_exc_o)
);

// File: tb/asi_sel_check_test.sv
module asi_sel_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 15;
  localparam int WATCHDOG = 5000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alt_i = 1'b0, imm_sel_i = 1'b0;
  logic [7:0] imm_asi_i = 8'h00, asi_reg_i = 8'h00;
  logic       nucleus_i = 1'b0, dflt_le_i = 1'b0, priv_i = 1'b0, ifetch_i = 1'b0;
  logic [7:0] asi_o;
  logic       little_o, priv_exc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  asi_sel_check uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .alt_i(alt_i), .imm_sel_i(imm_sel_i),
    .imm_asi_i(imm_asi_i), .asi_reg_i(asi_reg_i), .nucleus_i(nucleus_i),
    .dflt_le_i(dflt_le_i), .priv_i(priv_i), .ifetch_i(ifetch_i),
    .asi_o(asi_o), .little_o(little_o), .priv_exc_o(priv_exc_o)
  );

  // {alt, imm_sel, imm_asi, asi_reg, nuc, dle, priv, ifetch, exp_asi, exp_le, exp_exc}
  localparam logic [31:0] VEC [N_VEC] = '{
    {2'b00, 8'h55, 8'h66, 4'b0000, 8'h80, 2'b00},  // R3
    {2'b00, 8'h55, 8'h66, 4'b0100, 8'h88, 2'b10},  // R3 R9
    {2'b00, 8'h55, 8'h66, 4'b1000, 8'h04, 2'b00},  // R4 R8 nucleus unprivileged
    {2'b00, 8'h55, 8'h66, 4'b1100, 8'h0C, 2'b10},  // R4 R9
    {2'b10, 8'h88, 8'h10, 4'b0000, 8'h88, 2'b10},  // R5 R9
    {2'b11, 8'h88, 8'h10, 4'b0010, 8'h10, 2'b00},  // R6 R8 privileged
    {2'b11, 8'h88, 8'h10, 4'b0000, 8'h10, 2'b01},  // R6 R7
    {2'b10, 8'h7F, 8'h90, 4'b0000, 8'h7F, 2'b01},  // R7 upper restricted bound
    {2'b10, 8'h80, 8'h00, 4'b0000, 8'h80, 2'b00},  // R8 lower unrestricted bound
    {2'b10, 8'h0C, 8'hFF, 4'b0000, 8'h0C, 2'b11},  // R7 R9 coincident
    {2'b11, 8'h00, 8'h0C, 4'b0000, 8'h0C, 2'b11},  // R6 R7 R9 coincident via register
    {2'b11, 8'h00, 8'h0C, 4'b0010, 8'h0C, 2'b10},  // R8 R9
    {2'b10, 8'h8C, 8'h00, 4'b0000, 8'h8C, 2'b00},  // R9 bit3 set but big-endian
    {2'b10, 8'h0C, 8'h00, 4'b0101, 8'h80, 2'b00},  // R10
    {2'b00, 8'h0C, 8'h0C, 4'b1101, 8'h04, 2'b00}   // R10 nucleus fetch
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v);
    alt_i     = v[31];
    imm_sel_i = v[30];
    imm_asi_i = v[29:22];
    asi_reg_i = v[21:14];
    nucleus_i = v[13];
    dflt_le_i = v[12];
    priv_i    = v[11];
    ifetch_i  = v[10];
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    check("R1 asi", asi_o, 8'h00);
    check("R1 le", {7'd0, little_o}, 8'h00);
    check("R1 exc", {7'd0, priv_exc_o}, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk_i);
      drive(VEC[i]);
      @(negedge clk_i);
      check($sformatf("vec%0d asi", i), asi_o, VEC[i][9:2]);
      check($sformatf("vec%0d le R9", i), {7'd0, little_o}, {7'd0, VEC[i][1]});
      check($sformatf("vec%0d exc R7/R8", i), {7'd0, priv_exc_o}, {7'd0, VEC[i][0]});
    end

    // R2: outputs hold until the next rising edge
    @(negedge clk_i);
    drive({2'b10, 8'h0C, 8'h00, 4'b0000, 10'd0});
    @(negedge clk_i);
    drive({2'b10, 8'hA5, 8'h00, 4'b0010, 10'd0});
    #1;
    check("R2 hold asi", asi_o, 8'h0C);
    check("R2 hold exc", {7'd0, priv_exc_o}, 8'h01);
    @(negedge clk_i);
    check("R2 update asi", asi_o, 8'hA5);
    check("R2 update exc", {7'd0, priv_exc_o}, 8'h00);

    // R1: asynchronous reset in mid-run clears immediately
    drive({2'b10, 8'h0C, 8'h00, 4'b0000, 10'd0});
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async asi", asi_o, 8'h00);
    check("R1 async le", {7'd0, little_o}, 8'h00);
    check("R1 async exc", {7'd0, priv_exc_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R5 after reset", asi_o, 8'h0C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule